// File: doc/BRIEF.md
# Flash Program and Erase Engine

This block runs timed program and erase operations on a small non-volatile array. The array is modelled as registers: 64 words of 16 bits, in four sectors of 16 words each. A host starts an operation with a one-cycle command:

- A word program takes an address and data. It can only clear bits.
- A chip erase or a sector erase takes a sector mask. It first drives every selected word to zero and then sets the same words to all ones.

Each word pulse lasts a number of clock cycles set at an input. A second input sets an optional limit on how long the whole operation may run.

While an operation runs, the `ready` output stays low. Reads then return a polling status word instead of array data:

- a bit that reads as the complement of the target data;
- toggle bits that change on each status read;
- a failure bit.

When the operation ends, reads return array data again. Per-sector lock inputs keep sectors from being changed, and an override input lifts all locks while it is held. A hard-abort input stops any operation at once and releases the read outputs. After an aborted operation, `ready` stays low for a fixed recovery interval.

Top module: `nvm_op_engine`

## Requirements
- R1: Out of reset `ready` is 1 and `rd_vld` is 0. The array powers up erased, so every word reads 16'hFFFF.
- R2: A program command is `cmd_op`=2'd1 with `cmd_vld` high. It drives `ready` low from the next cycle for max(`pulse_cyc`,2) cycles. It then stores the old word AND `cmd_data`, and `ready` returns to 1.
- R3: A program whose data has a 1 where the stored word has a 0 leaves that bit at 0. The engine then stays in a failed state, with `ready` low and status bit 5 set, until a reset command (`cmd_op`=2'd0) arrives.
- R4: A chip erase (`cmd_op`=2'd2) or a sector erase (`cmd_op`=2'd3, with `cmd_secmask` bit i selecting the sector of word addresses i*16 to i*16+15) leaves every selected, unlocked word at 16'hFFFF. Other words are left as they were.
- R5: An erase first writes 16'h0000 to every selected word, in address order. Only after that pass does it write 16'hFFFF to the same words.
- R6: A read that starts while `ready` is low returns a status word. In that word:
  - bit 7 is the complement of bit 7 of the target data (the program data, or 1 for an erase);
  - bit 6 is 1 on the first status read of an operation and then alternates;
  - bit 2 does the same as bit 6 during an erase and is 0 during a program;
  - bit 5 is the failure flag;
  - every other bit is 0.
- R7: Once `ready` is back at 1, reads return stored data, and repeated reads of one word return the same value.
- R8: A command of any kind that arrives while an operation runs, a reset command included, has no effect.
- R9: `hard_rst` ends any operation at once and holds `rd_vld` at 0 while it is high. If an operation was running, `ready` stays 0 until RST_CYC cycles after `hard_rst` falls. If the engine was idle, `ready` stays 1.
- R10: A command that targets a locked sector does not change that sector. A program there, or an erase whose selected sectors are all locked, leaves `ready` at 1.
- R11: While `lock_override` is high, the locks have no effect on commands accepted in that time.
- R12: With a nonzero `tmo_limit`, an operation still running after more than `tmo_limit` cycles enters the failed state of R3. A `tmo_limit` of 0 disables the limit.
- R13: `rd_vld` is 1 exactly in the cycle after a cycle with `rd_en` high and `hard_rst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hard_rst | input | 1 | Abort input; ends any operation and releases the read outputs |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 reset, 1 program, 2 chip erase, 3 sector erase |
| cmd_addr | input | AW | Program word address |
| cmd_data | input | DW | Program data |
| cmd_secmask | input | NSEC | Sectors selected by a sector erase |
| sec_lock | input | NSEC | Per-sector lock bits |
| lock_override | input | 1 | Lifts every lock while high |
| pulse_cyc | input | CW | Cycles per word pulse (minimum 2 applied) |
| tmo_limit | input | TW | Operation time limit in cycles, 0 for none |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data or status word |
| rd_vld | output | 1 | Read data valid |
| ready | output | 1 | High when idle, low while busy, failed or recovering |

## Verification
The preprogram pass is the hardest behaviour to see from the ports. Reads return status for the whole erase, so the zeroed words are never visible while the erase runs. The bench therefore starts a sector erase and counts cycles from the skip and pulse lengths. It asserts `hard_rst` in the short window after the zeroing pass ends and before the first word is set back to ones. The selected words must then read zero after recovery, and the words around them must be unchanged.

// File: rtl/nvm_pkg.sv
`timescale 1ns/1ps
package nvm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PGM, ST_PRE, ST_ERS, ST_FAIL, ST_ABORT
  } eng_state_t;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_PROG  = 2'd1,
    OP_CHIP  = 2'd2,
    OP_SECT  = 2'd3
  } cmd_op_t;

  localparam int unsigned STB_POLL = 7;
  localparam int unsigned STB_TOG  = 6;
  localparam int unsigned STB_FAIL = 5;
  localparam int unsigned STB_ETOG = 2;
endpackage

// File: rtl/nvm_array.sv
`timescale 1ns/1ps
module nvm_array #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  // erased at power-up: all ones
  logic [DW-1:0] mem [DEPTH] = '{default: '1};

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvm_seq.sv
`timescale 1ns/1ps
module nvm_seq
  import nvm_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 6,
  parameter int NSEC    = 4,
  parameter int CW      = 8,
  parameter int TW      = 16,
  parameter int RST_CYC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hard_rst,
  input  logic            cmd_vld,
  input  logic [1:0]      cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [DW-1:0]   cmd_data,
  input  logic [NSEC-1:0] cmd_secmask,
  input  logic [NSEC-1:0] eff_lock,
  input  logic [CW-1:0]   pulse_cyc,
  input  logic [TW-1:0]   tmo_limit,
  input  logic [DW-1:0]   mem_q,
  output eng_state_t      st,
  output logic            ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_waddr,
  output logic [DW-1:0]   mem_wdata,
  output logic [AW-1:0]   op_addr,
  output logic            poll_bit,
  output logic            is_erase
);
  localparam int SW  = (NSEC > 1) ? $clog2(NSEC) : 1;
  localparam int RCW = $clog2(RST_CYC + 1);
  localparam logic [AW-1:0] LAST = AW'((1 << AW) - 1);

  eng_state_t      st_n;
  logic [DW-1:0]   op_data;
  logic [NSEC-1:0] act_mask;
  logic [AW-1:0]   idx;
  logic [CW-1:0]   cnt;
  logic [TW-1:0]   tmo_cnt;
  logic [RCW-1:0]  rcnt;

  cmd_op_t         op_c;
  logic [CW-1:0]   pulse_ld;
  logic [NSEC-1:0] erase_mask;
  logic [SW-1:0]   cmd_sec;
  logic            idx_act;
  logic            tmo_hit;
  logic            run;
  logic            step;

  always_comb begin
    op_c       = cmd_op_t'(cmd_op);
    pulse_ld   = (pulse_cyc < CW'(2)) ? CW'(2) : pulse_cyc;
    erase_mask = ((op_c == OP_CHIP) ? {NSEC{1'b1}} : cmd_secmask) & ~eff_lock;
    cmd_sec    = cmd_addr[AW-1 -: SW];
    idx_act    = act_mask[idx[AW-1 -: SW]];
    tmo_hit    = (tmo_limit != '0) && (tmo_cnt == tmo_limit);
    run        = (st == ST_PGM) || (st == ST_PRE) || (st == ST_ERS);
    step       = !idx_act || (cnt == CW'(1));
  end

  always_comb begin
    st_n      = st;
    mem_we    = 1'b0;
    mem_waddr = idx;
    mem_wdata = '0;
    if (hard_rst) begin
      st_n = (run || st == ST_ABORT) ? ST_ABORT : ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: if (cmd_vld) begin
          if (op_c == OP_PROG) begin
            if (!eff_lock[cmd_sec]) st_n = ST_PGM;
          end else if (op_c != OP_RESET) begin
            if (erase_mask != '0) st_n = ST_PRE;
          end
        end
        ST_PGM: begin
          if (tmo_hit) st_n = ST_FAIL;
          else if (cnt == CW'(1)) begin
            mem_we    = 1'b1;
            mem_waddr = op_addr;
            mem_wdata = mem_q & op_data;
            st_n      = (|(op_data & ~mem_q)) ? ST_FAIL : ST_IDLE;
          end
        end
        ST_PRE, ST_ERS: begin
          if (tmo_hit) st_n = ST_FAIL;
          else if (step) begin
            mem_we    = idx_act;
            mem_wdata = (st == ST_ERS) ? '1 : '0;
            if (idx == LAST) st_n = (st == ST_PRE) ? ST_ERS : ST_IDLE;
          end
        end
        ST_FAIL: if (cmd_vld && op_c == OP_RESET) st_n = ST_IDLE;
        ST_ABORT: if (rcnt == RCW'(1)) st_n = ST_IDLE;
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ready    <= 1'b1;
      idx      <= '0;
      cnt      <= '0;
      tmo_cnt  <= '0;
      rcnt     <= '0;
      op_addr  <= '0;
      op_data  <= '0;
      act_mask <= '0;
      is_erase <= 1'b0;
    end else begin
      st    <= st_n;
      ready <= (st_n == ST_IDLE);
      if (hard_rst) rcnt <= RCW'(RST_CYC);
      else if (st == ST_ABORT) rcnt <= rcnt - RCW'(1);
      if (st == ST_IDLE && st_n != ST_IDLE) begin
        op_addr  <= cmd_addr;
        op_data  <= cmd_data;
        act_mask <= erase_mask;
        is_erase <= (st_n == ST_PRE);
        idx      <= '0;
        cnt      <= pulse_ld;
        tmo_cnt  <= '0;
      end else if (run) begin
        tmo_cnt <= tmo_cnt + TW'(1);
        if (st != ST_PGM && step) begin
          idx <= idx + AW'(1);
          cnt <= pulse_ld;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  assign poll_bit = is_erase ? 1'b0 : ~op_data[7];
endmodule

// File: rtl/nvm_status.sv
`timescale 1ns/1ps
module nvm_status
  import nvm_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hard_rst,
  input  logic          rd_en,
  input  logic          stat_mode,
  input  logic          fail,
  input  logic          poll_bit,
  input  logic          is_erase,
  input  logic [DW-1:0] mem_q,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld
);
  logic          sel_q;
  logic          tog;
  logic [DW-1:0] stat_q;
  logic [DW-1:0] stat_w;
  logic          take;

  always_comb begin
    take             = rd_en && !hard_rst;
    stat_w           = '0;
    stat_w[STB_POLL] = poll_bit;
    stat_w[STB_TOG]  = ~tog;
    stat_w[STB_FAIL] = fail;
    stat_w[STB_ETOG] = is_erase & ~tog;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      sel_q  <= 1'b0;
      tog    <= 1'b0;
      stat_q <= '0;
    end else begin
      rd_vld <= take;
      if (take) begin
        sel_q <= stat_mode;
        if (stat_mode) stat_q <= stat_w;
      end
      if (take && stat_mode) tog <= ~tog;
      else if (!stat_mode) tog <= 1'b0;
    end
  end

  assign rd_data = sel_q ? stat_q : mem_q;
endmodule

// File: rtl/nvm_op_engine.sv
`timescale 1ns/1ps
module nvm_op_engine
  import nvm_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 6,
  parameter int NSEC    = 4,
  parameter int CW      = 8,
  parameter int TW      = 16,
  parameter int RST_CYC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hard_rst,
  input  logic            cmd_vld,
  input  logic [1:0]      cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [DW-1:0]   cmd_data,
  input  logic [NSEC-1:0] cmd_secmask,
  input  logic [NSEC-1:0] sec_lock,
  input  logic            lock_override,
  input  logic [CW-1:0]   pulse_cyc,
  input  logic [TW-1:0]   tmo_limit,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic            rd_vld,
  output logic            ready
);
  eng_state_t      st;
  logic            mem_we;
  logic [AW-1:0]   mem_waddr;
  logic [DW-1:0]   mem_wdata;
  logic [AW-1:0]   op_addr;
  logic [AW-1:0]   mem_raddr;
  logic [DW-1:0]   mem_q;
  logic            poll_bit;
  logic            is_erase;
  logic [NSEC-1:0] eff_lock;

  assign eff_lock  = lock_override ? '0 : sec_lock;
  assign mem_raddr = (st == ST_PGM) ? op_addr : rd_addr;

  nvm_seq #(
    .DW(DW), .AW(AW), .NSEC(NSEC), .CW(CW), .TW(TW), .RST_CYC(RST_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .hard_rst(hard_rst),
    .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_secmask(cmd_secmask), .eff_lock(eff_lock),
    .pulse_cyc(pulse_cyc), .tmo_limit(tmo_limit), .mem_q(mem_q),
    .st(st), .ready(ready), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .op_addr(op_addr), .poll_bit(poll_bit),
    .is_erase(is_erase)
  );

  nvm_array #(.DW(DW), .AW(AW)) u_arr (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_q)
  );

  nvm_status #(.DW(DW)) u_stat (
    .clk(clk), .rst(rst), .hard_rst(hard_rst), .rd_en(rd_en),
    .stat_mode(st != ST_IDLE), .fail(st == ST_FAIL), .poll_bit(poll_bit),
    .is_erase(is_erase), .mem_q(mem_q), .rd_data(rd_data), .rd_vld(rd_vld)
  );
endmodule

// File: rtl/nvm_op_engine_chk.sv
`timescale 1ns/1ps
module nvm_op_engine_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          hard_rst,
  input logic          cmd_vld,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          rd_vld,
  input logic          ready
);
  // R13
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && !hard_rst |=> rd_vld);

  // R13
  rd_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_vld);

  // R9
  rd_released_chk: assert property (@(posedge clk) disable iff (rst)
    hard_rst |=> !rd_vld);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> $past(cmd_vld));

  // R6
  stat_fmt_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && !hard_rst && !ready |=>
      (rd_data[DW-1:8] == '0) && (rd_data[4:3] == 2'b00) && (rd_data[1:0] == 2'b00));
endmodule

bind nvm_op_engine nvm_op_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .hard_rst(hard_rst), .cmd_vld(cmd_vld),
  .rd_en(rd_en), .rd_data(rd_data), .rd_vld(rd_vld), .ready(ready)
);

// File: tb/sim_nvm_op_engine.sv
`timescale 1ns/1ps
module sim_nvm_op_engine;
  localparam int RSTC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hard_rst = 1'b0;
  logic        cmd_vld = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [5:0]  cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic [3:0]  cmd_secmask = '0;
  logic [3:0]  sec_lock = '0;
  logic        lock_override = 1'b0;
  logic [7:0]  pulse_cyc = 8'd20;
  logic [15:0] tmo_limit = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        rd_vld;
  logic        ready;

  int nvec = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  nvm_op_engine #(.RST_CYC(RSTC)) u0 (
    .clk(clk), .rst(rst), .hard_rst(hard_rst), .cmd_vld(cmd_vld),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_secmask(cmd_secmask), .sec_lock(sec_lock),
    .lock_override(lock_override), .pulse_cyc(pulse_cyc),
    .tmo_limit(tmo_limit), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_vld(rd_vld), .ready(ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [5:0] a,
                       input logic [15:0] d, input logic [3:0] m);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_secmask = m;
    @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R13 rd_vld", rd_vld, 1);
    d = rd_data;
  endtask

  task automatic wait_ready(input int lim);
    int n = 0;
    while (!ready && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk("R2 ready returns", ready, 1);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 ready", ready, 1);
    chk("R1 rd_vld", rd_vld, 0);
    rd(6'd5, d);
    chk("R1 erased", d, 16'hFFFF);
    @(negedge clk);
    chk("R13 no vld", rd_vld, 0);
  endtask

  task automatic t_program;
    logic [15:0] d, d2;
    pulse_cyc = 8'd20;
    issue(2'd1, 6'd3, 16'h1234, 4'h0);
    chk("R2 busy", ready, 0);
    rd(6'd3, d);
    chk("R6 status first", d, 16'h00C0);
    rd(6'd3, d);
    chk("R6 status second", d, 16'h0080);
    wait_ready(100);
    rd(6'd3, d);
    rd(6'd3, d2);
    chk("R7 data", d, 16'h1234);
    chk("R7 stable", d2, 16'h1234);
    issue(2'd1, 6'd3, 16'h0230, 4'h0);
    wait_ready(100);
    rd(6'd3, d);
    chk("R2 and", d, 16'h0230);
  endtask

  task automatic t_fail_program;
    logic [15:0] d;
    issue(2'd1, 6'd3, 16'h0231, 4'h0);
    repeat (30) @(negedge clk);
    chk("R3 held busy", ready, 0);
    rd(6'd3, d);
    chk("R3 status fail", d, 16'h00E0);
    issue(2'd0, 6'd0, 16'h0, 4'h0);
    chk("R3 reset cmd", ready, 1);
    rd(6'd3, d);
    chk("R3 bit stays 0", d, 16'h0230);
  endtask

  task automatic t_erase_busy;
    logic [15:0] d;
    issue(2'd1, 6'd50, 16'h00FF, 4'h0);
    wait_ready(100);
    issue(2'd1, 6'd33, 16'h0000, 4'h0);
    wait_ready(100);
    issue(2'd3, 6'd0, 16'h0, 4'b0100);
    chk("R4 busy", ready, 0);
    rd(6'd33, d);
    chk("R6 erase status first", d, 16'h0044);
    rd(6'd33, d);
    chk("R6 erase status second", d, 16'h0000);
    issue(2'd1, 6'd50, 16'h000F, 4'h0);
    issue(2'd0, 6'd0, 16'h0, 4'h0);
    chk("R8 reset cmd ignored", ready, 0);
    wait_ready(2000);
    rd(6'd50, d);
    chk("R8 program ignored", d, 16'h00FF);
    rd(6'd33, d);
    chk("R4 sector erased", d, 16'hFFFF);
  endtask

  task automatic t_protect;
    logic [15:0] d;
    sec_lock = 4'b0010;
    issue(2'd1, 6'd20, 16'h0000, 4'h0);
    chk("R10 program locked no busy", ready, 1);
    rd(6'd20, d);
    chk("R10 program locked", d, 16'hFFFF);
    issue(2'd3, 6'd0, 16'h0, 4'b0010);
    chk("R10 erase locked no busy", ready, 1);
    lock_override = 1'b1;
    issue(2'd1, 6'd21, 16'h2222, 4'h0);
    wait_ready(100);
    lock_override = 1'b0;
    rd(6'd21, d);
    chk("R11 override program", d, 16'h2222);
    issue(2'd1, 6'd5, 16'h1111, 4'h0);
    wait_ready(100);
    issue(2'd3, 6'd0, 16'h0, 4'b0011);
    wait_ready(4000);
    rd(6'd5, d);
    chk("R4 unlocked erased", d, 16'hFFFF);
    rd(6'd21, d);
    chk("R10 locked kept", d, 16'h2222);
    lock_override = 1'b1;
    issue(2'd3, 6'd0, 16'h0, 4'b0010);
    wait_ready(4000);
    lock_override = 1'b0;
    rd(6'd21, d);
    chk("R11 override erase", d, 16'hFFFF);
    sec_lock = 4'b0000;
  endtask

  task automatic t_preprog_abort;
    logic [15:0] d;
    pulse_cyc = 8'd3;
    @(negedge clk);
    hard_rst = 1'b1;
    @(negedge clk);
    hard_rst = 1'b0;
    chk("R9 idle stays ready", ready, 1);
    issue(2'd3, 6'd0, 16'h0, 4'b0010);
    repeat (99) @(negedge clk);
    hard_rst = 1'b1; rd_en = 1'b1; rd_addr = 6'd16;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R9 outputs released", rd_vld, 0);
    chk("R9 busy held", ready, 0);
    @(negedge clk);
    hard_rst = 1'b0;
    repeat (RSTC - 1) @(negedge clk);
    chk("R9 still recovering", ready, 0);
    @(negedge clk);
    chk("R9 recovered", ready, 1);
    rd(6'd16, d);
    chk("R5 preprogrammed first", d, 16'h0000);
    rd(6'd31, d);
    chk("R5 preprogrammed last", d, 16'h0000);
    rd(6'd15, d);
    chk("R5 neighbour untouched", d, 16'hFFFF);
  endtask

  task automatic t_timeout;
    logic [15:0] d;
    pulse_cyc = 8'd3;
    tmo_limit = 16'd10;
    issue(2'd2, 6'd0, 16'h0, 4'h0);
    repeat (20) @(negedge clk);
    chk("R12 timed out busy", ready, 0);
    rd(6'd0, d);
    chk("R12 status fail", d, 16'h0064);
    issue(2'd0, 6'd0, 16'h0, 4'h0);
    chk("R12 reset cmd", ready, 1);
    tmo_limit = 16'd0;
    issue(2'd2, 6'd0, 16'h0, 4'h0);
    wait_ready(1000);
    rd(6'd16, d);
    chk("R4 chip erase", d, 16'hFFFF);
    rd(6'd50, d);
    chk("R4 chip erase far", d, 16'hFFFF);
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_program();
    t_fail_program();
    t_erase_busy();
    t_protect();
    t_preprog_abort();
    t_timeout();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nvec++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule